// File: doc/BRIEF.md
# Receive Character Buffer with Switchable Depth

This block holds characters that a serial receiver has assembled, until the register-read side collects them. It runs in one of two modes. With queueing on, it is a circular buffer of `DEPTH` entries. With queueing off, it is a single holding slot. A control-word write selects the mode, and the receiver sees a ready signal that follows whichever depth is currently in force.

The read side watches a data output that always shows the entry under the read pointer. It pulses a read strobe to consume that entry. Two registered flags tell software whether anything is waiting and whether the buffer has reached its current capacity. All pointer arithmetic wraps by masking with one less than the effective depth, so `DEPTH` must be a power of two.

Top module: `uart_rx_buf`

## Requirements
- R1: After reset, the mode is single-slot, the empty flag is 1, the full flag is 0 and ready is 1.
- R2: The effective depth is `DEPTH` while bit 4 (`EN_BIT`) of the last control word is 1, and 1 otherwise. Ready is 1 exactly when the occupancy is below the effective depth and no control write is in progress that cycle.
- R3: An accepted push stores the character at index (pointer + occupancy) masked by (effective depth − 1), and the occupancy then rises by one.
- R4: The data output shows the entry at the read pointer. A read strobe with nonzero occupancy lowers the occupancy by one and advances the pointer, masked by (effective depth − 1).
- R5: A read strobe with zero occupancy still shows the entry at the pointer, and changes neither the pointer nor the occupancy.
- R6: The empty flag is cleared by any accepted push, and is set when a read takes the occupancy to zero.
- R7: The full flag is set when a push brings the occupancy up to the effective depth. A read that consumes an entry clears it. In single-slot mode, one character makes the buffer full.
- R8: A push and a consuming read in the same cycle leave the occupancy unchanged. Both the write index and the read index come from the values held before that cycle.
- R9: A control write that changes the enable bit empties the buffer: the occupancy and the pointer both become 0. A control write that leaves the bit unchanged keeps the contents. Any push or read strobe in a control-write cycle has no effect.
- R10: A push while ready is 0 is discarded. The stored entries and the occupancy are left untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | CTL_W | Control word; bit EN_BIT enables queueing |
| rx_valid | input | 1 | Receiver offers a character |
| rx_data | input | DATA_W | Character from the receiver |
| rx_ready | output | 1 | Buffer accepts a push this cycle |
| rd_stb | input | 1 | Data-register read strobe |
| rd_data | output | DATA_W | Entry at the read pointer |
| rx_empty | output | 1 | Nothing is waiting |
| rx_full | output | 1 | Occupancy equals the effective depth |

## Verification
The assertions check the following on every cycle:
- the occupancy never exceeds `DEPTH`;
- the pointer stays at zero in single-slot mode;
- the flags agree with the occupancy;
- ready is low whenever the buffer is full;
- a lone push raises the occupancy by exactly one;
- a read on an empty buffer leaves the pointer in place.

Some behaviour can only be shown by the bench's scenarios, which compare the data output against a model. This covers which character lands in which slot, that the order is preserved across the wrap, and that a mode change flushes while a same-bit control write does not. It also covers that the character returned after a simultaneous push and read is the older one.

// File: rtl/uart_rx_buf_pkg.sv
package uart_rx_buf_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_PUSH = 2'b01,
        OP_POP  = 2'b10,
        OP_BOTH = 2'b11
    } rx_op_e;

endpackage

// File: rtl/uart_rx_buf_store.sv
module uart_rx_buf_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int PTR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] slot_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [DATA_W-1:0] slot_d;

        always_comb begin
            slot_d = slot_q[i];
            if (wr_en && (wr_idx == PTR_W'(i))) begin
                slot_d = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[i] <= '0;
            end else begin
                slot_q[i] <= slot_d;
            end
        end
    end

    assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/uart_rx_buf_ctrl.sv
module uart_rx_buf_ctrl
    import uart_rx_buf_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int CTL_W  = 8,
    parameter int EN_BIT = 4,
    parameter int PTR_W  = $clog2(DEPTH),
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             push_req,
    input  logic             pop_req,
    output logic             ready,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_idx,
    output logic [PTR_W-1:0] rd_idx,
    output logic             empty,
    output logic             full
);

    localparam logic [CNT_W-1:0] FULL_DEPTH = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] FULL_MASK  = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic             en;
        logic [PTR_W-1:0] ptr;
        logic [CNT_W-1:0] cnt;
        logic             empty;
        logic             full;
    } state_t;

    state_t   cur_q, nxt_d;
    rx_op_e   op;
    logic [CNT_W-1:0] depth_cur, depth_nxt;
    logic [PTR_W-1:0] mask;
    logic             do_push, do_pop, new_en;

    always_comb begin
        nxt_d     = cur_q;
        depth_cur = cur_q.en ? FULL_DEPTH : CNT_W'(1);
        mask      = cur_q.en ? FULL_MASK : '0;
        ready     = !ctl_we && (cur_q.cnt < depth_cur);
        do_push   = push_req && ready;
        do_pop    = pop_req && !ctl_we && (cur_q.cnt != '0);
        op        = rx_op_e'({do_pop, do_push});
        wr_en     = do_push;
        wr_idx    = (cur_q.ptr + cur_q.cnt[PTR_W-1:0]) & mask;
        rd_idx    = cur_q.ptr;
        new_en    = ctl_wdata[EN_BIT];

        if (ctl_we) begin
            if (new_en != cur_q.en) begin
                nxt_d.ptr = '0;
                nxt_d.cnt = '0;
            end
            nxt_d.en = new_en;
        end else begin
            if (do_pop) begin
                nxt_d.ptr = (cur_q.ptr + PTR_W'(1)) & mask;
            end
            case (op)
                OP_PUSH: nxt_d.cnt = cur_q.cnt + CNT_W'(1);
                OP_POP:  nxt_d.cnt = cur_q.cnt - CNT_W'(1);
                default: nxt_d.cnt = cur_q.cnt;
            endcase
        end

        depth_nxt   = nxt_d.en ? FULL_DEPTH : CNT_W'(1);
        nxt_d.empty = (nxt_d.cnt == '0);
        nxt_d.full  = (nxt_d.cnt == depth_nxt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{en: 1'b0, ptr: '0, cnt: '0, empty: 1'b1, full: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign empty = cur_q.empty;
    assign full  = cur_q.full;

    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.cnt <= FULL_DEPTH);

    // R9
    single_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_q.en |-> cur_q.ptr == '0);

    // R6
    empty_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty == (cur_q.cnt == '0));

    // R7
    full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !ready);

    // R3
    push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !pop_req) |=> cur_q.cnt == $past(cur_q.cnt) + CNT_W'(1));

    // R5
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push_req && !ctl_we && empty) |=> $stable(cur_q.ptr));

endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int CTL_W  = 8,
    parameter int EN_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_empty,
    output logic              rx_full
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             wr_en;
    logic [PTR_W-1:0] wr_idx, rd_idx;

    uart_rx_buf_ctrl #(
        .DEPTH (DEPTH),
        .CTL_W (CTL_W),
        .EN_BIT(EN_BIT),
        .PTR_W (PTR_W),
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_we   (ctl_we),
        .ctl_wdata(ctl_wdata),
        .push_req (rx_valid),
        .pop_req  (rd_stb),
        .ready    (rx_ready),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .rd_idx   (rd_idx),
        .empty    (rx_empty),
        .full     (rx_full)
    );

    uart_rx_buf_store #(
        .DATA_W(DATA_W),
        .DEPTH (DEPTH),
        .PTR_W (PTR_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(rx_data),
        .rd_idx (rd_idx),
        .rd_data(rd_data)
    );

endmodule

// File: tb/tb_uart_rx_buf.sv
module tb_uart_rx_buf;

    localparam int DATA_W = 8;
    localparam int DEPTH  = 16;
    localparam int CTL_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ctl_we = 1'b0;
    logic [CTL_W-1:0]  ctl_wdata = '0;
    logic              rx_valid = 1'b0;
    logic [DATA_W-1:0] rx_data = '0;
    logic              rd_stb = 1'b0;
    logic              rx_ready, rx_empty, rx_full;
    logic [DATA_W-1:0] rd_data;

    int checks = 0;
    int errors = 0;

    logic [DATA_W-1:0] m_mem [DEPTH];
    int m_ptr = 0;
    int m_cnt = 0;
    bit m_en  = 0;

    always #4 clk = ~clk;

    uart_rx_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CTL_W(CTL_W), .EN_BIT(4)) dut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .rd_stb(rd_stb), .rd_data(rd_data), .rx_empty(rx_empty), .rx_full(rx_full)
    );

    function automatic int m_depth();
        return m_en ? DEPTH : 1;
    endfunction

    function automatic bit exp_ready(bit we);
        return !we && (m_cnt < m_depth());
    endfunction

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // one clock cycle: check flags, drive inputs, check ready/data, advance model
    task automatic cycle(bit push, logic [DATA_W-1:0] d, bit pop, bit we, logic [CTL_W-1:0] cw);
        bit acc_push, acc_pop;
        @(negedge clk);
        check("R6", int'(rx_empty), int'(m_cnt == 0), "empty flag");
        check("R7", int'(rx_full), int'(m_cnt == m_depth()), "full flag");
        rx_valid = push; rx_data = d; rd_stb = pop; ctl_we = we; ctl_wdata = cw;
        #1;
        check("R2", int'(rx_ready), int'(exp_ready(we)), "ready");
        if (pop)
            check(m_cnt == 0 ? "R5" : "R4", int'(rd_data), int'(m_mem[m_ptr]), "read data");
        if (we) begin
            if (cw[4] != m_en) begin
                m_cnt = 0;
                m_ptr = 0;
            end
            m_en = cw[4];
        end else begin
            acc_push = push && (m_cnt < m_depth());
            acc_pop  = pop && (m_cnt > 0);
            if (acc_push) m_mem[(m_ptr + m_cnt) & (m_depth() - 1)] = d;
            if (acc_pop)  m_ptr = (m_ptr + 1) & (m_depth() - 1);
            m_cnt = m_cnt + int'(acc_push) - int'(acc_pop);
        end
    endtask

    task automatic idle_inputs();
        @(negedge clk);
        rx_valid = 0; rd_stb = 0; ctl_we = 0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1", int'(rx_empty), 1, "empty after reset");
        check("R1", int'(rx_full), 0, "full after reset");
        check("R1", int'(rx_ready), 1, "ready after reset");

        // single-slot mode: one char fills it (R7), second push dropped (R10)
        cycle(1, 8'hA1, 0, 0, 8'h00);
        cycle(1, 8'hB2, 0, 0, 8'h00);
        cycle(0, 8'h00, 1, 0, 8'h00);   // R10: must read A1, not B2
        cycle(0, 8'h00, 1, 0, 8'h00);   // R5: empty read
        // R8 in single-slot: empty + push + pop -> one entry
        cycle(1, 8'hC3, 1, 0, 8'h00);
        cycle(0, 8'h00, 1, 0, 8'h00);

        // R9: enable queueing (flush), fill to the end, wrap
        cycle(0, 8'h00, 0, 1, 8'h10);
        for (int i = 0; i < DEPTH + 2; i++) cycle(1, 8'(8'h40 + i), 0, 0, 8'h00);  // R3, R10
        for (int i = 0; i < 5; i++) cycle(0, 8'h00, 1, 0, 8'h00);                 // R4
        for (int i = 0; i < 5; i++) cycle(1, 8'(8'h80 + i), 1, 0, 8'h00);         // R8
        // R9: same-bit control write keeps contents; push/pop ignored that cycle
        cycle(1, 8'hEE, 1, 1, 8'h13);
        for (int i = 0; i < DEPTH + 1; i++) cycle(0, 8'h00, 1, 0, 8'h00);         // R4 wrap, R5
        // R9: mode change with data inside flushes it
        cycle(1, 8'h11, 0, 0, 8'h00);
        cycle(1, 8'h22, 0, 0, 8'h00);
        cycle(0, 8'h00, 0, 1, 8'h00);
        idle_inputs();
        #1;
        check("R9", int'(rx_empty), 1, "empty after flush");
        check("R9", int'(rx_ready), 1, "ready after flush");

        // constrained random
        for (int n = 0; n < 4000; n++) begin
            int r;
            bit we;
            r  = int'($urandom % 100);
            we = (r < 2);
            cycle(($urandom % 100) < (n % 400 < 200 ? 70 : 35), 8'($urandom),
                  ($urandom % 100) < (n % 400 < 200 ? 35 : 70), we,
                  8'($urandom) & (($urandom % 2) ? 8'hFF : 8'hEF));
        end
        idle_inputs();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule